// File: doc/BRIEF.md
# Multi-Hart Machine Timer Compare Unit

This block is the timer peripheral of a small multi-core system. It holds one shared 64-bit time counter and one 64-bit compare register for each hart, and it drives one timer-interrupt line per hart. The time counter advances by one on every clock in which the timebase tick enable is high. Interrupt line N is high in every cycle in which the time value is greater than or equal to compare register N.

Software reaches the registers through a single-cycle request/response port that accepts 4-byte or 8-byte accesses. Compare register N sits in the 8-byte slot at offset 8*N, and the time counter sits in the slot at offset 0x7FF8. A 4-byte access selects one 32-bit half of a slot. A 4-byte write merges the new half with the half that is already stored. The hart number of a slot is the hart-index base plus the slot index, and the interrupt line is chosen by subtracting the base again.

On reset the time counter is loaded with zero in the same way as a full 64-bit time write. Compare registers reset to all ones, so no interrupt is pending until software programs a compare value.

Top module: `hart_timer_cmp`

## Requirements
- R1: After reset the time reads 0, every compare register reads 64'hFFFF_FFFF_FFFF_FFFF, every interrupt line is low, and rsp_err and rsp_rdata are 0.
- R2: The time counter increases by exactly 1 at each clock edge at which tick_en is high and no time write is accepted. At any other edge it holds its value.
- R3: In every cycle, timer_irq[N] equals (time >= compare N), with both values treated as unsigned 64-bit numbers.
- R4: An 8-byte access (req_size64=1) at offset 0 of slot N (address 8*N, N < NUM_HARTS) reads or writes the full 64-bit compare N. Read data appears on rsp_rdata in the cycle after the request.
- R5: A 4-byte access (req_size64=0) at slot offset 0 reaches bits [31:0], and at slot offset 4 it reaches bits [63:32]. Reads return the half in rsp_rdata[31:0] with rsp_rdata[63:32] = 0. Writes take req_wdata[31:0] and leave the other half unchanged.
- R6: After a compare write, the interrupt of that hart is high in the next cycle if the new value is less than or equal to the time, and low otherwise.
- R7: The slot at address 0x7FF8 is the time counter and follows the same size and half rules as R4 and R5. A time write takes precedence over a tick in the same cycle. The new time is compared against every hart's compare register in the next cycle.
- R8: An access is rejected when the address slot is neither the time slot nor below NUM_HARTS, when the slot offset is neither 0 nor 4, or when it is an 8-byte access at offset 4. A rejected access returns rsp_rdata = 0, pulses rsp_err high for one cycle, and changes no register.
- R9: In a cycle after no request, rsp_err is 0 and rsp_rdata is 0. A write that is accepted also returns rsp_rdata = 0 and rsp_err = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Timebase tick; the time advances on each cycle in which it is high |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_size64 | input | 1 | 1 for an 8-byte access, 0 for a 4-byte access |
| req_addr | input | ADDR_W | Byte address within the block |
| req_wdata | input | 64 | Write data; a 4-byte write uses bits [31:0] |
| rsp_rdata | output | 64 | Read data, valid the cycle after the request |
| rsp_err | output | 1 | One-cycle pulse for a rejected access |
| timer_irq | output | NUM_HARTS | One timer interrupt per hart |

## Verification
Two things can land on the time counter at the same clock edge: a time write from the bus and a tick from the timebase. A compare write can also coincide with a tick. The bench issues a time write, and separately a compare write, while tick_en is held high for that same edge. It then reads the time back and checks that the written value won with no extra increment. It also checks that every interrupt line in the next cycle matches the model's unsigned comparison, so a compare that equals the post-tick time is judged correctly.

// File: rtl/hart_timer_cmp.sv
module hart_timer_cmp #(
  parameter int NUM_HARTS = 4,
  parameter int HART_BASE = 0,
  parameter int ADDR_W    = 15
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick_en,
  input  logic                 req_valid,
  input  logic                 req_write,
  input  logic                 req_size64,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic [63:0]          req_wdata,
  output logic [63:0]          rsp_rdata,
  output logic                 rsp_err,
  output logic [NUM_HARTS-1:0] timer_irq
);
  localparam int SLOT_W = ADDR_W - 3;
  localparam logic [SLOT_W-1:0] TIME_SLOT = '1;

  logic [63:0] mtime_q;
  logic [63:0] cmp_q [NUM_HARTS];
  logic [63:0] cmp_sel;

  wire [SLOT_W-1:0] slot    = req_addr[ADDR_W-1:3];
  wire [2:0]        ofs     = req_addr[2:0];
  wire              is_time = (slot == TIME_SLOT);
  wire [31:0]       hart_id = 32'(HART_BASE) + 32'(slot);
  wire [31:0]       line    = hart_id - 32'(HART_BASE);
  wire              hart_ok = line < 32'(NUM_HARTS);
  wire              ofs_ok  = (ofs == 3'd0) || (ofs == 3'd4 && !req_size64);
  wire              hit     = req_valid && ofs_ok && (is_time || hart_ok);
  wire              wr_hit  = hit && req_write;

  always_comb begin
    cmp_sel = '0;
    for (int i = 0; i < NUM_HARTS; i++)
      if (line == 32'(i)) cmp_sel = cmp_q[i];
  end

  wire [63:0] cur = is_time ? mtime_q : cmp_sel;

  wire [63:0] rd_val = req_size64 ? cur :
                       ofs[2]     ? {32'b0, cur[63:32]} : {32'b0, cur[31:0]};

  wire [63:0] merged = req_size64 ? req_wdata :
                       ofs[2]     ? {req_wdata[31:0], cur[31:0]} :
                                    {cur[63:32], req_wdata[31:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mtime_q   <= '0;
      rsp_rdata <= '0;
      rsp_err   <= 1'b0;
    end else begin
      rsp_rdata <= (hit && !req_write) ? rd_val : '0;
      rsp_err   <= req_valid && !hit;
      if (wr_hit && is_time)
        mtime_q <= merged;
      else if (tick_en)
        mtime_q <= mtime_q + 64'd1;
    end
  end

  for (genvar g = 0; g < NUM_HARTS; g++) begin : g_hart
    always_ff @(posedge clk) begin
      if (!rst_n)
        cmp_q[g] <= '1;
      else if (wr_hit && !is_time && line == 32'(g))
        cmp_q[g] <= merged;
    end
    assign timer_irq[g] = mtime_q >= cmp_q[g];
  end
endmodule

module hart_timer_cmp_chk #(
  parameter int NUM_HARTS = 4,
  parameter int ADDR_W    = 15
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 tick_en,
  input logic                 req_valid,
  input logic                 req_write,
  input logic                 req_size64,
  input logic [ADDR_W-1:0]    req_addr,
  input logic [63:0]          mtime_q,
  input logic [63:0]          rsp_rdata,
  input logic                 rsp_err,
  input logic [NUM_HARTS-1:0] timer_irq
);
  wire time_slot = &req_addr[ADDR_W-1:3];
  wire time_wr   = req_valid && req_write && time_slot &&
                   (req_addr[2:0] == 3'd0 || (req_addr[2:0] == 3'd4 && !req_size64));
  wire bad       = req_valid &&
                   (!(time_slot || int'(req_addr[ADDR_W-1:3]) < NUM_HARTS) ||
                    !(req_addr[2:0] == 3'd0 || (req_addr[2:0] == 3'd4 && !req_size64)));

  p_time_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && !time_wr) |=> mtime_q == $past(mtime_q) + 64'd1);

  p_time_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_en && !time_wr) |=> $stable(mtime_q));

  p_bad_rsp_r8: assert property (@(posedge clk) disable iff (!rst_n)
    bad |=> rsp_err && rsp_rdata == 64'd0);

  p_bad_nochange_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bad && !tick_en) |=> $stable(mtime_q) && $stable(timer_irq));

  p_idle_rsp_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_err && rsp_rdata == 64'd0);

  p_err_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !bad |=> !rsp_err);
endmodule

bind hart_timer_cmp hart_timer_cmp_chk #(.NUM_HARTS(NUM_HARTS), .ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .req_valid(req_valid),
  .req_write(req_write), .req_size64(req_size64), .req_addr(req_addr),
  .mtime_q(mtime_q), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err), .timer_irq(timer_irq)
);

// File: tb/hart_timer_cmp_tb_top.sv
module hart_timer_cmp_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NH = 4;
  localparam logic [14:0] TADDR = 15'h7FF8;

  logic clk = 0, rst_n = 0, tick_en = 0;
  logic req_valid = 0, req_write = 0, req_size64 = 0;
  logic [14:0] req_addr = '0;
  logic [63:0] req_wdata = '0;
  logic [63:0] rsp_rdata;
  logic rsp_err;
  logic [NH-1:0] timer_irq;

  int total = 0, bad = 0;
  logic [63:0] m_time;
  logic [63:0] m_cmp [NH];

  always #(CLK_PERIOD/2) clk = ~clk;

  hart_timer_cmp #(.NUM_HARTS(NH), .HART_BASE(2), .ADDR_W(15)) dut_i (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .req_valid(req_valid),
    .req_write(req_write), .req_size64(req_size64), .req_addr(req_addr),
    .req_wdata(req_wdata), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
    .timer_irq(timer_irq)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic bit m_bad(input int slot, input int ofs, input bit s64);
    bit ofs_ok = (ofs == 0) || (ofs == 4 && !s64);
    return !(ofs_ok && (slot == 4095 || slot < NH));
  endfunction

  function automatic logic [63:0] m_cur(input int slot);
    return (slot == 4095) ? m_time : m_cmp[slot];
  endfunction

  function automatic logic [63:0] m_read(input int slot, input int ofs, input bit s64);
    logic [63:0] c;
    if (m_bad(slot, ofs, s64)) return 64'd0;
    c = m_cur(slot);
    if (s64) return c;
    return (ofs == 4) ? {32'd0, c[63:32]} : {32'd0, c[31:0]};
  endfunction

  function automatic void m_write(input int slot, input int ofs, input bit s64, input logic [63:0] d);
    logic [63:0] c, n;
    if (m_bad(slot, ofs, s64)) return;
    c = m_cur(slot);
    n = s64 ? d : (ofs == 4) ? {d[31:0], c[31:0]} : {c[63:32], d[31:0]};
    if (slot == 4095) m_time = n; else m_cmp[slot] = n;
  endfunction

  function automatic logic [NH-1:0] m_irq();
    logic [NH-1:0] v;
    for (int i = 0; i < NH; i++) v[i] = m_time >= m_cmp[i];
    return v;
  endfunction

  task automatic bus(input bit w, input bit s64, input int slot, input int ofs,
                     input logic [63:0] d, input bit tk,
                     output logic [63:0] rd, output logic er);
    @(negedge clk);
    req_valid = 1; req_write = w; req_size64 = s64;
    req_addr = 15'((slot << 3) | ofs); req_wdata = d; tick_en = tk;
    @(negedge clk);
    rd = rsp_rdata; er = rsp_err;
    req_valid = 0; tick_en = 0;
  endtask

  task automatic wr(input string req, input bit s64, input int slot, input int ofs,
                    input logic [63:0] d, input bit tk);
    logic [63:0] rd; logic er;
    bus(1, s64, slot, ofs, d, tk, rd, er);
    if (tk) m_time = m_time + 64'd1;
    m_write(slot, ofs, s64, d);
    chk({req, " write err"}, {63'd0, er}, {63'd0, m_bad(slot, ofs, s64)});
    chk({req, " write rdata"}, rd, 64'd0);
    chk({req, " irq"}, 64'(timer_irq), 64'(m_irq()));
  endtask

  task automatic rd_chk(input string req, input bit s64, input int slot, input int ofs);
    logic [63:0] rd; logic er;
    bus(0, s64, slot, ofs, 64'd0, 0, rd, er);
    chk({req, " read data"}, rd, m_read(slot, ofs, s64));
    chk({req, " read err"}, {63'd0, er}, {63'd0, m_bad(slot, ofs, s64)});
  endtask

  task automatic dump_all(input string req);
    for (int i = 0; i < NH; i++) rd_chk(req, 1, i, 0);
    rd_chk(req, 1, 4095, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    bad++;
    $display("FAIL watchdog act=%h exp=%h", 64'd0, 64'd1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    m_time = '0;
    for (int i = 0; i < NH; i++) m_cmp[i] = '1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 irq", 64'(timer_irq), 64'd0);
    chk("R1 err", {63'd0, rsp_err}, 64'd0);
    chk("R1 rdata", rsp_rdata, 64'd0);
    dump_all("R1");
    chk("R9 idle err", {63'd0, rsp_err}, 64'd0);

    // R4 full compare writes, R5 half reads
    for (int i = 0; i < NH; i++) begin
      wr("R4", 1, i, 0, 64'h1234_5678_0000_0000 + 64'(i) * 64'h1_0001_0101, 0);
      rd_chk("R4", 1, i, 0);
      rd_chk("R5 lo", 0, i, 0);
      rd_chk("R5 hi", 0, i, 4);
    end
    // R5 merging
    wr("R5 lo merge", 0, 1, 0, 64'hFFFF_FFFF_CAFE_F00D, 0);
    rd_chk("R5 lo merge", 1, 1, 0);
    wr("R5 hi merge", 0, 2, 4, 64'h0BAD_0BAD_ABCD_0123, 0);
    rd_chk("R5 hi merge", 1, 2, 0);

    // R7 time write and R6 compare in the past / equal / future
    wr("R7 time", 1, 4095, 0, 64'd100, 0);
    wr("R6 past", 1, 0, 0, 64'd50, 0);
    wr("R6 equal", 1, 1, 0, 64'd100, 0);
    wr("R6 future", 1, 2, 0, 64'd101, 0);
    wr("R6 max", 1, 3, 0, 64'hFFFF_FFFF_FFFF_FFFF, 0);
    chk("R6 vector", 64'(timer_irq), 64'b0011);
    // R2/R3 single tick crosses compare 2
    @(negedge clk); tick_en = 1; @(negedge clk); tick_en = 0;
    m_time = m_time + 64'd1;
    chk("R3 after tick", 64'(timer_irq), 64'b0111);
    rd_chk("R2 one tick", 1, 4095, 0);
    // R7 rewrite time low: re-evaluation clears all
    wr("R7 time rewind", 1, 4095, 0, 64'd0, 0);
    chk("R7 rewind vector", 64'(timer_irq), 64'b0000);
    // R2 multi tick
    @(negedge clk); tick_en = 1; repeat (37) @(negedge clk); tick_en = 0;
    m_time = m_time + 64'd37;
    rd_chk("R2 37 ticks", 1, 4095, 0);
    chk("R3 at 37", 64'(timer_irq), 64'(m_irq()));
    // R2 hold with tick low
    repeat (5) @(negedge clk);
    rd_chk("R2 hold", 1, 4095, 0);

    // R7 same-cycle: time write and tick together, write wins
    wr("R7 write vs tick", 1, 4095, 0, 64'd500, 1);
    m_time = 64'd500;
    rd_chk("R7 write vs tick", 1, 4095, 0);
    // R6 compare write with tick in the same edge, equal to post-tick time
    wr("R6 cmp vs tick", 1, 3, 0, 64'd501, 1);
    chk("R6 cmp vs tick irq3", 64'(timer_irq[3]), 64'd1);
    // R7 half writes to time across 32-bit boundary
    wr("R7 time hi", 0, 4095, 4, 64'd1, 0);
    wr("R7 time lo", 0, 4095, 0, 64'd0, 0);
    rd_chk("R7 time halves", 1, 4095, 0);
    rd_chk("R7 time hi read", 0, 4095, 4);
    wr("R3 cmp below 2^32", 1, 0, 0, 64'hFFFF_FFFF, 0);
    wr("R3 cmp above 2^32", 1, 1, 0, 64'h1_0000_0001, 0);
    chk("R3 64-bit compare", 64'(timer_irq[1:0]), 64'b01);

    // R8 sweep of slots, offsets and sizes for reads
    for (int s = 0; s < 7; s++) begin
      for (int o = 0; o < 8; o++) begin
        rd_chk("R8 sweep4", 0, (s == 6) ? 4095 : s, o);
        rd_chk("R8 sweep8", 1, (s == 6) ? 4095 : s, o);
      end
    end
    // R8 rejected writes change nothing
    wr("R8 bad slot", 1, 4, 0, 64'd7, 0);
    wr("R8 bad slot", 0, 4094, 4, 64'd7, 0);
    wr("R8 bad ofs", 0, 0, 2, 64'd7, 0);
    wr("R8 bad ofs", 1, 4095, 6, 64'd7, 0);
    wr("R8 wide hi", 1, 2, 4, 64'd7, 0);
    dump_all("R8 unchanged");
    @(negedge clk);
    chk("R9 idle after", {63'd0, rsp_err}, 64'd0);
    chk("R9 idle rdata", rsp_rdata, 64'd0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule